// File: doc/BRIEF.md
# Variable-Length Byte-Code Execution Core

This block is a small multi-cycle processor that executes a handful of variable-length instructions stored one byte per address. It drives a byte address to a synchronous instruction memory, takes the returned byte one cycle later, and builds each instruction from one, two or five bytes. Multi-byte immediates are assembled least significant byte first. The core executes an instruction only after all of its bytes have arrived.

The architectural state is four 32-bit registers (accumulator, base, counter and index) and an instruction pointer. The instruction set has immediate loads, a register add, an index increment and a counted loop branch that decrements the counter. A dedicated byte stops the core cleanly. Any unknown encoding stops it and raises a flag that stays set until reset. All registers and the instruction pointer are visible on debug outputs, so a surrounding environment can check a program's results.

Top module: `byte_cisc_core`

## Requirements
- R1: While reset is held and right after it, the instruction pointer reads 0x200, all four registers read zero, and both `halted` and `illegal` are low.
- R2: Opcode bytes 0xB8, 0xBB, 0xB9 and 0xBE are each followed by four immediate bytes, least significant first. They load that 32-bit value into the accumulator, base, counter and index register respectively. For example, 0A 00 00 00 loads 10.
- R3: After an instruction executes, the instruction pointer equals its start address plus its length: 5 for immediate loads, 2 for add and loop, 1 for increment and stop. A load at 0x200 leaves 0x205.
- R4: The byte pair 0x01 0xD8 writes accumulator + base, modulo 2^32, into the accumulator and leaves the base unchanged.
- R5: Byte 0x46 adds one to the index register, wrapping from 0xFFFFFFFF to 0.
- R6: Byte 0xE2 followed by a signed 8-bit displacement d writes counter − 1 into the counter. If the new counter is nonzero, execution continues at (address after the displacement byte) + d. Otherwise it falls through. A counter of 0 therefore becomes 0xFFFFFFFF and the branch is taken.
- R7: Byte 0xF4 raises `halted`. The instruction pointer then holds the address after that byte, and the pointer and registers stay unchanged until reset.
- R8: A first byte that is not listed in R2 and R4 to R7 raises both `illegal` and `halted`, and so does a 0x01 whose second byte is not 0xD8. Both flags stay set until reset, and no register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_en | output | 1 | Read strobe for the instruction memory |
| imem_addr | output | 16 | Byte address presented to the instruction memory |
| imem_data | input | 8 | Byte returned one cycle after the address |
| dbg_eax | output | 32 | Accumulator register |
| dbg_ebx | output | 32 | Base register |
| dbg_ecx | output | 32 | Counter register |
| dbg_esi | output | 32 | Index register |
| dbg_ip | output | 16 | Instruction pointer |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Stop was caused by an unknown encoding |

## Verification
- **Byte order.** Distinct immediate bytes such as 0A 0B 0C 0D show whether immediates are assembled in the right order; a byte-swapped core would produce 0x0A0B0C0D.
- **Add carry.** Adding 0xFFFFFFFF checks that the carry out of bit 31 is dropped.
- **Loop branch.** A backward loop, a forward skip, a loop that falls through at one, and a loop entered with a zero counter cover the branch decision. A core that tests the old counter, or adds the displacement to the wrong base address, ends with a wrong index count or a wrong stop address.
- **Illegal encodings.** Both unknown encodings are run: a bad first byte and a bad second byte after 0x01. A core that ignores either one would run on into the zero bytes that follow.
- **Index wrap.** The increment is started from 0xFFFFFFFF, so it must wrap to zero.
- **Stop and reset.** Stopping and stickiness are checked by idling after each stop. Reset is checked while the core is stopped with `illegal` raised.

// File: rtl/core_pkg.sv
package core_pkg;
   typedef enum logic [1:0] {ST_REQ, ST_CAPT, ST_EXEC, ST_HALT} core_state_t;
   typedef enum logic [2:0] {K_MOVI, K_ADD, K_INC, K_LOOP, K_HLT, K_BAD} op_kind_t;

   localparam logic [7:0] OP_LD_A   = 8'hB8;
   localparam logic [7:0] OP_LD_C   = 8'hB9;
   localparam logic [7:0] OP_LD_B   = 8'hBB;
   localparam logic [7:0] OP_LD_I   = 8'hBE;
   localparam logic [7:0] OP_ADD    = 8'h01;
   localparam logic [7:0] ADD_MODRM = 8'hD8;
   localparam logic [7:0] OP_INC_I  = 8'h46;
   localparam logic [7:0] OP_LOOP   = 8'hE2;
   localparam logic [7:0] OP_STOP   = 8'hF4;

   localparam int NREG = 4;
   localparam logic [1:0] RI_A = 2'd0;
   localparam logic [1:0] RI_B = 2'd1;
   localparam logic [1:0] RI_C = 2'd2;
   localparam logic [1:0] RI_I = 2'd3;
endpackage

// File: rtl/core_decode.sv
module core_decode
   import core_pkg::*;
#(
   parameter int LEN_W   = 3,
   parameter int IMM_LEN = 5
) (
   input  logic [7:0]       op,
   output op_kind_t         kind,
   output logic [LEN_W-1:0] len,
   output logic [1:0]       dst
);
   always_comb begin
      kind = K_BAD;
      len  = LEN_W'(1);
      dst  = RI_A;
      unique case (op)
         OP_LD_A:  begin kind = K_MOVI; len = LEN_W'(IMM_LEN); dst = RI_A; end
         OP_LD_B:  begin kind = K_MOVI; len = LEN_W'(IMM_LEN); dst = RI_B; end
         OP_LD_C:  begin kind = K_MOVI; len = LEN_W'(IMM_LEN); dst = RI_C; end
         OP_LD_I:  begin kind = K_MOVI; len = LEN_W'(IMM_LEN); dst = RI_I; end
         OP_ADD:   begin kind = K_ADD;  len = LEN_W'(2); end
         OP_INC_I: begin kind = K_INC;  len = LEN_W'(1); end
         OP_LOOP:  begin kind = K_LOOP; len = LEN_W'(2); end
         OP_STOP:  begin kind = K_HLT;  len = LEN_W'(1); end
         default:  begin kind = K_BAD;  len = LEN_W'(1); end
      endcase
   end
endmodule

// File: rtl/core_imm_pack.sv
module core_imm_pack #(
   parameter int IMM_BYTES = 4,
   parameter bit LSB_FIRST = 1'b1
) (
   input  logic [IMM_BYTES*8-1:0] stream,
   output logic [IMM_BYTES*8-1:0] value
);
   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign value = stream;
      end else begin : g_msb_first
         for (genvar k = 0; k < IMM_BYTES; k++) begin : g_swap
            assign value[8*k +: 8] = stream[8*(IMM_BYTES-1-k) +: 8];
         end
      end
   endgenerate
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
   parameter int DATA_W = 32,
   parameter int NUM    = 4,
   localparam int IDX_W = $clog2(NUM)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we,
   input  logic [IDX_W-1:0]      waddr,
   input  logic [DATA_W-1:0]     wdata,
   output logic [NUM*DATA_W-1:0] rd_flat
);
   generate
      for (genvar r = 0; r < NUM; r++) begin : g_reg
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        q <= '0;
            else if (we && waddr == IDX_W'(r)) q <= wdata;
         end
         assign rd_flat[r*DATA_W +: DATA_W] = q;
      end
   endgenerate
endmodule

// File: rtl/byte_cisc_core.sv
module byte_cisc_core
   import core_pkg::*;
#(
   parameter int               ADDR_W    = 16,
   parameter int               DATA_W    = 32,
   parameter logic [ADDR_W-1:0] START_IP = 16'h0200,
   parameter bit               LSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              imem_en,
   output logic [ADDR_W-1:0] imem_addr,
   input  logic [7:0]        imem_data,
   output logic [DATA_W-1:0] dbg_eax,
   output logic [DATA_W-1:0] dbg_ebx,
   output logic [DATA_W-1:0] dbg_ecx,
   output logic [DATA_W-1:0] dbg_esi,
   output logic [ADDR_W-1:0] dbg_ip,
   output logic              halted,
   output logic              illegal
);
   localparam int IMM_BYTES = DATA_W / 8;
   localparam int MAX_LEN   = 1 + IMM_BYTES;
   localparam int LEN_W     = $clog2(MAX_LEN + 1);

   generate
      if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data_w
         $error("DATA_W must be a multiple of 8 and at least 16");
      end
      if (ADDR_W <= 8) begin : g_bad_addr_w
         $error("ADDR_W must exceed the 8-bit displacement");
      end
   endgenerate

   core_state_t       state;
   logic [ADDR_W-1:0] ip;
   logic [LEN_W-1:0]  cnt, len_q;
   op_kind_t          kind_q;
   logic [1:0]        dst_q;
   logic [7:0]        ibuf [1:MAX_LEN-1];
   logic              halt_q, bad_q;

   op_kind_t          dec_kind;
   logic [LEN_W-1:0]  dec_len;
   logic [1:0]        dec_dst;

   core_decode #(.LEN_W(LEN_W), .IMM_LEN(MAX_LEN)) u_dec (
      .op(imem_data), .kind(dec_kind), .len(dec_len), .dst(dec_dst));

   logic [IMM_BYTES*8-1:0] imm_stream, imm_val;
   generate
      for (genvar k = 0; k < IMM_BYTES; k++) begin : g_stream
         assign imm_stream[8*k +: 8] = ibuf[k+1];
      end
   endgenerate

   core_imm_pack #(.IMM_BYTES(IMM_BYTES), .LSB_FIRST(LSB_FIRST)) u_imm (
      .stream(imm_stream), .value(imm_val));

   logic                   we;
   logic [1:0]             waddr;
   logic [DATA_W-1:0]      wdata;
   logic [NREG*DATA_W-1:0] rd_flat;

   core_regfile #(.DATA_W(DATA_W), .NUM(NREG)) u_rf (
      .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata), .rd_flat(rd_flat));

   assign dbg_eax = rd_flat[RI_A*DATA_W +: DATA_W];
   assign dbg_ebx = rd_flat[RI_B*DATA_W +: DATA_W];
   assign dbg_ecx = rd_flat[RI_C*DATA_W +: DATA_W];
   assign dbg_esi = rd_flat[RI_I*DATA_W +: DATA_W];

   logic [DATA_W-1:0] ecx_dec;
   logic              take_br, bad_modrm;
   assign ecx_dec = dbg_ecx - DATA_W'(1);

   always_comb begin
      we        = 1'b0;
      waddr     = dst_q;
      wdata     = imm_val;
      take_br   = 1'b0;
      bad_modrm = 1'b0;
      if (state == ST_EXEC) begin
         case (kind_q)
            K_MOVI: we = 1'b1;
            K_ADD: begin
               if (ibuf[1] == ADD_MODRM) begin
                  we = 1'b1; waddr = RI_A; wdata = dbg_eax + dbg_ebx;
               end else begin
                  bad_modrm = 1'b1;
               end
            end
            K_INC:  begin we = 1'b1; waddr = RI_I; wdata = dbg_esi + DATA_W'(1); end
            K_LOOP: begin we = 1'b1; waddr = RI_C; wdata = ecx_dec; take_br = (ecx_dec != '0); end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_REQ;
         ip     <= START_IP;
         cnt    <= '0;
         len_q  <= '0;
         kind_q <= K_BAD;
         dst_q  <= RI_A;
         halt_q <= 1'b0;
         bad_q  <= 1'b0;
         for (int i = 1; i < MAX_LEN; i++) ibuf[i] <= '0;
      end else begin
         unique case (state)
            ST_REQ: state <= ST_CAPT;
            ST_CAPT: begin
               ip <= ip + ADDR_W'(1);
               if (cnt == '0) begin
                  kind_q <= dec_kind;
                  len_q  <= dec_len;
                  dst_q  <= dec_dst;
                  if (dec_kind == K_BAD || dec_kind == K_HLT) begin
                     halt_q <= 1'b1;
                     bad_q  <= (dec_kind == K_BAD);
                     state  <= ST_HALT;
                  end else if (dec_len == LEN_W'(1)) begin
                     state <= ST_EXEC;
                  end else begin
                     cnt   <= LEN_W'(1);
                     state <= ST_REQ;
                  end
               end else begin
                  ibuf[cnt] <= imem_data;
                  if (cnt == len_q - LEN_W'(1)) begin
                     cnt   <= '0;
                     state <= ST_EXEC;
                  end else begin
                     cnt   <= cnt + LEN_W'(1);
                     state <= ST_REQ;
                  end
               end
            end
            ST_EXEC: begin
               if (bad_modrm) begin
                  halt_q <= 1'b1;
                  bad_q  <= 1'b1;
                  state  <= ST_HALT;
               end else begin
                  if (take_br) ip <= ip + {{(ADDR_W-8){ibuf[1][7]}}, ibuf[1]};
                  state <= ST_REQ;
               end
            end
            default: state <= ST_HALT;
         endcase
      end
   end

   assign imem_en   = (state == ST_REQ);
   assign imem_addr = ip;
   assign dbg_ip    = ip;
   assign halted    = halt_q;
   assign illegal   = bad_q;

   assert_ip_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CAPT) |=> (dbg_ip == $past(dbg_ip) + ADDR_W'(1)));
   assert_add_sum_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && kind_q == K_ADD && ibuf[1] == ADD_MODRM)
      |=> (dbg_eax == $past(dbg_eax) + $past(dbg_ebx)));
   assert_inc_index_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && kind_q == K_INC) |=> (dbg_esi == $past(dbg_esi) + DATA_W'(1)));
   assert_loop_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_EXEC && kind_q == K_LOOP) |=> (dbg_ecx == $past(dbg_ecx) - DATA_W'(1)));
   assert_halt_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      halted |=> ($stable(dbg_ip) && $stable(dbg_eax) && $stable(dbg_esi) && halted));
   assert_illegal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |=> (illegal && halted));
endmodule

// File: tb/sim_byte_cisc_core.sv
module sim_byte_cisc_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        imem_en;
   logic [15:0] imem_addr;
   logic [7:0]  imem_data;
   logic [31:0] dbg_eax, dbg_ebx, dbg_ecx, dbg_esi;
   logic [15:0] dbg_ip;
   logic        halted, illegal;

   int total = 0;
   int bad   = 0;
   int cyc   = 0;

   logic [7:0] mem [0:4095];

   always #10 clk = ~clk;

   always @(posedge clk) begin
      imem_data <= mem[imem_addr[11:0]];
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         bad   = bad + 1;
         total = total + 1;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   byte_cisc_core u0 (
      .clk(clk), .rst_n(rst_n), .imem_en(imem_en), .imem_addr(imem_addr),
      .imem_data(imem_data), .dbg_eax(dbg_eax), .dbg_ebx(dbg_ebx),
      .dbg_ecx(dbg_ecx), .dbg_esi(dbg_esi), .dbg_ip(dbg_ip),
      .halted(halted), .illegal(illegal));

   typedef struct packed {
      logic [63:0]  tag;
      logic [7:0]   len;
      logic [127:0] prog;
      logic [31:0]  eax, ebx, ecx, esi;
      logic [15:0]  ip;
      logic         ill;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{"R2 R3 R4", 8'd13, 128'hB80A000000BB0A00000001D8F4, 32'd20, 32'd10, 32'd0, 32'd0, 16'h020D, 1'b0},
      '{"R6 R5   ", 8'd14, 128'hB904000000BE0000000046E2FDF4, 32'd0, 32'd0, 32'd0, 32'd4, 16'h020E, 1'b0},
      '{"R2 R4   ", 8'd13, 128'hB80A0B0C0DBBFFFFFFFF01D8F4, 32'h0D0C0B09, 32'hFFFFFFFF, 32'd0, 32'd0, 16'h020D, 1'b0},
      '{"R5 R3   ", 8'd7,  128'hBEFFFFFFFF46F4, 32'd0, 32'd0, 32'd0, 32'd0, 16'h0207, 1'b0},
      '{"R8      ", 8'd1,  128'h90, 32'd0, 32'd0, 32'd0, 32'd0, 16'h0201, 1'b1},
      '{"R8 R4   ", 8'd2,  128'h01C0, 32'd0, 32'd0, 32'd0, 32'd0, 16'h0202, 1'b1},
      '{"R6 fall ", 8'd10, 128'hB901000000E2024646F4, 32'd0, 32'd0, 32'd0, 32'd2, 16'h020A, 1'b0},
      '{"R6 fwd  ", 8'd9,  128'hB902000000E20146F4, 32'd0, 32'd0, 32'd1, 32'd0, 16'h0209, 1'b0},
      '{"R6 zero ", 8'd8,  128'hB900000000E200F4, 32'd0, 32'd0, 32'hFFFFFFFF, 32'd0, 16'h0208, 1'b0},
      '{"R2 R7   ", 8'd11, 128'hBE78563412B9EFBEADDEF4, 32'd0, 32'd0, 32'hDEADBEEF, 32'h12345678, 16'h020B, 1'b0}
   };

   task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      total = total + 1;
      if (act !== exp) begin
         bad = bad + 1;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic load_prog(input vec_t v);
      @(negedge clk);
      rst_n = 1'b0;
      for (int a = 16'h200; a < 16'h220; a++) mem[a] = 8'h00;
      for (int i = 0; i < int'(v.len); i++) mem[16'h200 + i] = v.prog[8*(int'(v.len) - 1 - i) +: 8];
      repeat (2) @(negedge clk);
   endtask

   task automatic run_to_halt();
      rst_n = 1'b1;
      for (int n = 0; n < 2000 && !halted; n++) @(negedge clk);
   endtask

   task automatic reset_state_check(input string req);
      check(req, "ip", {16'h0, dbg_ip}, 32'h200);
      check(req, "eax", dbg_eax, 32'd0);
      check(req, "ebx", dbg_ebx, 32'd0);
      check(req, "ecx", dbg_ecx, 32'd0);
      check(req, "esi", dbg_esi, 32'd0);
      check(req, "halted", {31'd0, halted}, 32'd0);
      check(req, "illegal", {31'd0, illegal}, 32'd0);
   endtask

   initial begin
      for (int a = 0; a < 4096; a++) mem[a] = 8'h00;

      load_prog(VECS[0]);
      reset_state_check("R1");

      for (int v = 0; v < NV; v++) begin
         string t;
         logic [15:0] ip_hold;
         t = string'(VECS[v].tag);
         load_prog(VECS[v]);
         run_to_halt();
         check(t, "halted", {31'd0, halted}, 32'd1);
         check(t, "eax", dbg_eax, VECS[v].eax);
         check(t, "ebx", dbg_ebx, VECS[v].ebx);
         check(t, "ecx", dbg_ecx, VECS[v].ecx);
         check(t, "esi", dbg_esi, VECS[v].esi);
         check(t, "ip", {16'h0, dbg_ip}, {16'h0, VECS[v].ip});
         check(t, "illegal", {31'd0, illegal}, {31'd0, VECS[v].ill});
         ip_hold = dbg_ip;
         repeat (12) @(negedge clk);
         check("R7", "ip after idle", {16'h0, dbg_ip}, {16'h0, ip_hold});
         check("R8", "illegal after idle", {31'd0, illegal}, {31'd0, VECS[v].ill});
         check("R7", "halted after idle", {31'd0, halted}, 32'd1);
      end

      // R1: reset taken while stopped with illegal raised clears everything
      load_prog(VECS[4]);
      run_to_halt();
      check("R8", "illegal before reset", {31'd0, illegal}, 32'd1);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      reset_state_check("R1");

      // R1: reset in the middle of a loop program returns to the start state
      load_prog(VECS[1]);
      rst_n = 1'b1;
      repeat (25) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      reset_state_check("R1");
      rst_n = 1'b1;
      run_to_halt();
      check("R6", "esi after rerun", dbg_esi, 32'd4);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule